// File: doc/BRIEF.md
# Resolver Carrier Waveform Generator

This block drives the excitation coil of a resolver. It produces a one-bit pulse-density stream whose local density follows a chosen carrier shape: rectangle, triangle or sine. An external amplifier filters and buffers the stream. A second output, the half-cycle sign, is high while the carrier is in its positive half. A downstream rectifier uses it to fold the demodulated sine and cosine coil signals.

One carrier period is split into 1024 steps. A clock divider sets how many system clocks each step lasts, so the carrier frequency is the system clock divided by 1024 times that count. The density comparison uses a free-running compare counter. When the bit-reversed compare mode is enabled, that counter is read with its bits reversed, which spreads the ones through the step and raises the switching rate of the output. A polarity control inverts the carrier and the sign together.

Top module: `resolver_carrier_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `carrier` and `sign` are 0, and the step count, divider count and compare counter are held at zero. After `enable` rises, the waveform restarts at step 0.
- R2: Each step lasts the number of clocks selected by `div_sel`: 0→2, 1→4, 2→8, 3→16, 4→32, and 5, 6 or 7→12. A full period is therefore 1024 times that count; for example, 12 clocks per step gives 12288 clocks.
- R3: A period has 1024 steps (0 to 1023), after which it wraps to step 0. Before inversion, `sign` is 1 during steps 0–511 and 0 during steps 512–1023.
- R4: A 10-bit compare counter advances by one every enabled clock. With `bitrev_en` = 0 the compare value is the counter itself; with `bitrev_en` = 1 it is the counter with bit 9 swapped with bit 0, bit 8 with bit 1, and so on. Before inversion, `carrier` is 1 exactly when the amplitude A is strictly greater than the compare value.
- R5: When `shape_sel` = 0 (rectangle), A = 1023 for steps 0–511 and A = 0 for steps 512–1023.
- R6: When `shape_sel` = 1 (triangle), with h the step modulo 512, A = 2·h for steps 0–511 and A = 2·(511−h) for steps 512–1023.
- R7: When `shape_sel` = 2 (sine, parabolic approximation), let d = floor(h·(511−h)/128). Then A = 512+d for steps 0–511 and A = 512−d for steps 512–1023.
- R8: When `shape_sel` = 3 (mid level), A = 512 at every step.
- R9: When `invert` = 1 and the block is enabled, both `carrier` and `sign` are the complement of their non-inverted values.
- R10: `carrier` and `sign` are registered. Their values after a clock edge reflect the step, compare counter and inputs just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low clears and holds it |
| shape_sel | input | 2 | Waveform select: 0 rectangle, 1 triangle, 2 sine, 3 mid level |
| div_sel | input | 3 | Clocks-per-step select (see R2) |
| bitrev_en | input | 1 | Compare against the bit-reversed counter |
| invert | input | 1 | Invert carrier and sign |
| carrier | output | 1 | Pulse-density carrier bit |
| sign | output | 1 | Positive-half-cycle flag for the rectifier |

## Verification
Every output is due one clock after the state it describes. The step index moves on once per N clocks, where N comes from `div_sel`. The compare counter moves every clock. The reference model advances its own step, divider and compare counts at each rising edge, using the inputs and its pre-edge state, in the same edge the design registers. Outputs are compared at the falling edge that follows. Period lengths are measured as the clock distance between successive rising edges of `sign`. All inputs change only at falling edges.

// File: rtl/crg_pkg.sv
package crg_pkg;
  localparam int DIV_W = 6;

  typedef enum logic [1:0] {
    SHP_RECT = 2'd0,
    SHP_TRI  = 2'd1,
    SHP_SINE = 2'd2,
    SHP_MID  = 2'd3
  } shape_e;

  function automatic logic [DIV_W-1:0] clocks_per_step(input logic [2:0] sel);
    logic [DIV_W-1:0] n;
    case (sel)
      3'd0:    n = DIV_W'(2);
      3'd1:    n = DIV_W'(4);
      3'd2:    n = DIV_W'(8);
      3'd3:    n = DIV_W'(16);
      3'd4:    n = DIV_W'(32);
      default: n = DIV_W'(12);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/crg_step_timer.sv
module crg_step_timer
  import crg_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        div_sel,
  output logic [DIV_W-1:0]  div_cnt,
  output logic [STEP_W-1:0] step_idx
);
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = clocks_per_step(div_sel) - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      step_idx <= '0;
    end else if (!enable) begin
      div_cnt  <= '0;
      step_idx <= '0;
    end else if (div_cnt >= last_cnt) begin
      div_cnt  <= '0;
      step_idx <= step_idx + STEP_W'(1);
    end else begin
      div_cnt  <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/crg_shape.sv
module crg_shape
  import crg_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic [STEP_W-1:0] step_idx,
  input  logic [1:0]        shape_sel,
  output logic [STEP_W-1:0] amp
);
  localparam int PROD_W = 2 * STEP_W;
  localparam int SHIFT  = STEP_W - 3;
  localparam logic [STEP_W-1:0] MID = STEP_W'(1) << (STEP_W - 1);

  logic              upper_half;
  logic [STEP_W-2:0] h;
  logic [PROD_W-1:0] prod;
  logic [STEP_W-1:0] dev;

  assign upper_half = step_idx[STEP_W-1];
  assign h          = step_idx[STEP_W-2:0];
  assign prod       = {{(STEP_W+1){1'b0}}, h} * {{(STEP_W+1){1'b0}}, ~h};
  assign dev        = STEP_W'(prod >> SHIFT);

  always_comb begin
    case (shape_e'(shape_sel))
      SHP_RECT: amp = upper_half ? '0 : '1;
      SHP_TRI:  amp = upper_half ? {~h, 1'b0} : {h, 1'b0};
      SHP_SINE: amp = upper_half ? (MID - dev) : (MID + dev);
      default:  amp = MID;
    endcase
  end
endmodule

// File: rtl/crg_pdm.sv
module crg_pdm #(
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bitrev_en,
  input  logic              invert,
  input  logic [STEP_W-1:0] amp,
  input  logic              pos_half,
  output logic              carrier,
  output logic              sign
);
  logic [STEP_W-1:0] cmp_cnt;
  logic [STEP_W-1:0] cmp_rev;
  logic [STEP_W-1:0] cmp_val;

  for (genvar i = 0; i < STEP_W; i++) begin : g_rev
    assign cmp_rev[i] = cmp_cnt[STEP_W-1-i];
  end

  assign cmp_val = bitrev_en ? cmp_rev : cmp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_cnt <= '0;
      carrier <= 1'b0;
      sign    <= 1'b0;
    end else if (!enable) begin
      cmp_cnt <= '0;
      carrier <= 1'b0;
      sign    <= 1'b0;
    end else begin
      cmp_cnt <= cmp_cnt + STEP_W'(1);
      carrier <= (amp > cmp_val) ^ invert;
      sign    <= pos_half ^ invert;
    end
  end
endmodule

// File: rtl/resolver_carrier_gen.sv
module resolver_carrier_gen
  import crg_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] shape_sel,
  input  logic [2:0] div_sel,
  input  logic       bitrev_en,
  input  logic       invert,
  output logic       carrier,
  output logic       sign
);
  logic [DIV_W-1:0]  div_cnt;
  logic [STEP_W-1:0] step_idx;
  logic [STEP_W-1:0] amp;

  crg_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .div_sel  (div_sel),
    .div_cnt  (div_cnt),
    .step_idx (step_idx)
  );

  crg_shape #(.STEP_W(STEP_W)) u_shape (
    .step_idx  (step_idx),
    .shape_sel (shape_sel),
    .amp       (amp)
  );

  crg_pdm #(.STEP_W(STEP_W)) u_pdm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .bitrev_en (bitrev_en),
    .invert    (invert),
    .amp       (amp),
    .pos_half  (~step_idx[STEP_W-1]),
    .carrier   (carrier),
    .sign      (sign)
  );
endmodule

// File: rtl/crg_checker.sv
module crg_checker
  import crg_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              invert,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [STEP_W-1:0] step_idx,
  input logic              carrier,
  input logic              sign
);
  localparam int MAX_STEP_CLKS = 32;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!carrier && !sign)); // R1

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < DIV_W'(MAX_STEP_CLKS)); // R2

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && div_cnt != '0) |-> $stable(step_idx)); // R2

  AST_STEP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable && !$stable(step_idx)) |->
      step_idx == STEP_W'($past(step_idx) + STEP_W'(1))); // R3

  AST_SIGN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> sign == ($past(~step_idx[STEP_W-1]) ^ $past(invert))); // R9
endmodule

bind resolver_carrier_gen crg_checker #(.STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .invert   (invert),
  .div_cnt  (div_cnt),
  .step_idx (step_idx),
  .carrier  (carrier),
  .sign     (sign)
);

// File: tb/resolver_carrier_gen_test.sv
module resolver_carrier_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] shape_sel = 2'd0;
  logic [2:0] div_sel = 3'd0;
  logic       bitrev_en = 1'b0;
  logic       invert = 1'b0;
  wire        carrier;
  wire        sign;

  resolver_carrier_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .shape_sel(shape_sel),
    .div_sel(div_sel), .bitrev_en(bitrev_en), .invert(invert),
    .carrier(carrier), .sign(sign)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  int    cyc = 0;
  int    m_cnt = 0, m_step = 0, m_cmp = 0;
  bit    e_car = 0, e_sgn = 0;
  string e_tag = "R1";
  bit    last_s = 0;
  int    rise_prev = -1, rise_last = -1;

  function automatic int steps_clks(input int d);
    case (d)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      default: return 12;
    endcase
  endfunction

  function automatic int amp_of(input int s, input int m);
    int h, d;
    h = s % 512;
    d = (h * (511 - h)) / 128;
    case (m)
      0: return (s < 512) ? 1023 : 0;
      1: return (s < 512) ? 2 * h : 2 * (511 - h);
      2: return (s < 512) ? 512 + d : 512 - d;
      default: return 512;
    endcase
  endfunction

  function automatic int rev10(input int v);
    int r = 0;
    for (int i = 0; i < 10; i++) if (((v >> i) & 1) != 0) r |= 1 << (9 - i);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference: evaluate from pre-edge state, then advance (R10)
  always @(posedge clk) begin
    int cv;
    cyc++;
    if (!rst_n || !enable) begin
      e_car = 0; e_sgn = 0; m_cnt = 0; m_step = 0; m_cmp = 0; e_tag = "R1";
    end else begin
      cv = bitrev_en ? rev10(m_cmp) : m_cmp;
      e_car = (amp_of(m_step, int'(shape_sel)) > cv) ^ invert;
      e_sgn = (m_step < 512) ^ invert;
      if (invert) e_tag = "R9 R10";
      else if (bitrev_en) e_tag = "R4 R10";
      else case (shape_sel)
        2'd0: e_tag = "R5 R10";
        2'd1: e_tag = "R6 R10";
        2'd2: e_tag = "R7 R10";
        default: e_tag = "R8 R10";
      endcase
      m_cmp = (m_cmp + 1) % 1024;
      if (m_cnt >= steps_clks(int'(div_sel)) - 1) begin
        m_cnt = 0;
        m_step = (m_step + 1) % 1024;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(carrier === e_car, e_tag, int'(carrier), int'(e_car));
      check(sign === e_sgn, (e_tag == "R1") ? "R1" : "R3", int'(sign), int'(e_sgn));
      if (sign && !last_s) begin
        rise_prev = rise_last;
        rise_last = cyc;
      end
      last_s = sign;
    end
  end

  task automatic idle(input int n);
    enable = 1'b0;
    repeat (n) @(negedge clk);
    check(carrier === 1'b0 && sign === 1'b0, "R1", int'({carrier, sign}), 0);
    rise_prev = -1;
    rise_last = -1;
  endtask

  task automatic run_cfg(input int shp, input int dv, input bit br, input bit inv, input int n);
    shape_sel = 2'(shp);
    div_sel   = 3'(dv);
    bitrev_en = br;
    invert    = inv;
    enable    = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_period(input int expect_clks, input string req);
    check(rise_prev >= 0 && (rise_last - rise_prev) == expect_clks, req,
          rise_last - rise_prev, expect_clks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(carrier === 1'b0 && sign === 1'b0, "R1", int'({carrier, sign}), 0);
    rst_n = 1'b1;
    idle(2);

    run_cfg(0, 0, 0, 0, 4200);           // rectangle, 2 clocks/step
    check_period(2048, "R2");
    idle(3);
    run_cfg(1, 1, 0, 0, 8300);           // triangle, 4 clocks/step
    check_period(4096, "R2");
    idle(3);
    run_cfg(2, 0, 0, 0, 4200);           // sine
    check_period(2048, "R3");
    idle(3);
    run_cfg(2, 0, 1, 0, 2200);           // sine, bit-reversed compare
    idle(3);
    run_cfg(0, 1, 1, 0, 4200);           // rectangle, bit-reversed compare
    idle(3);
    run_cfg(3, 2, 0, 0, 2000);           // mid level
    idle(3);
    run_cfg(1, 0, 0, 1, 2200);           // triangle inverted
    idle(3);
    run_cfg(2, 0, 1, 1, 2200);           // sine inverted, bit-reversed
    idle(3);
    run_cfg(0, 5, 0, 0, 24700);          // 12 clocks/step
    check_period(12288, "R2");
    idle(3);
    run_cfg(1, 4, 0, 0, 65700);          // 32 clocks/step
    check_period(32768, "R2");
    run_cfg(1, 3, 0, 0, 600);            // divider change while running
    idle(3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 180000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule